// File: doc/BRIEF.md
# Four-Lane PHY Management Register Bank

This block is a small set of management registers for a four-lane 10 Gb/s physical layer, reached through a plain register port (address, write data, write strobe, read strobe, read data) that an MDIO frame handler drives. It holds an equalizer boost setting, an output adjust word (drive amplitude, per-lane pre-emphasis enables and a two-bit test field), a status word that latches per-lane signal-detect drops and loss-of-signal events until software reads them, and a self-clearing soft-reset command that pulses a reset line for the datapath engines.

The reset values of the configuration fields depend on a mode input: one profile suits a fiber link, the other a copper link. Raw per-lane status comes in every cycle. Configuration fields and the soft-reset pulse go out as plain ports. Read data is registered: it appears the cycle after the read strobe and holds until the next read.

Top module: `pma_reg_bank`

## Requirements
- R1: On reset with `mode_copper`=0 the outputs read eq_coeff=0h, amp_ctrl=5h, preemph_en=0h, test_ctl=00b. All signal-detect status bits reset to 1 and all loss bits reset to 0.
- R2: On reset with `mode_copper`=1 the outputs read eq_coeff=Ch, amp_ctrl=3h, preemph_en=Fh, test_ctl=00b.
- R3: Address C006h holds the boost coefficient in bits 3:0, where 0h means no boost and Fh means maximum boost. It is readable and writable. Bits 15:4 read as 0, and writes to them are ignored.
- R4: Address C00Bh is readable and writable in bits 9:0. Amplitude is in bits 9:6. Pre-emphasis enable for lane i is in bit 2+i. The test field is in bits 1:0. Bits 15:10 read as 0.
- R5: Address C00Ah reads signal-detect for lane i in bit 4+i and loss for lane i in bit i. Bits 15:8 read as 0. Read data appears on `reg_rdata` the cycle after `reg_re` and holds until the next read.
- R6: A lane's signal-detect bit drops to 0 in the cycle after its raw `lane_sigdet` input is 0. It stays 0 until a read of C00Ah, after which it is 1 again.
- R7: A lane's loss bit rises to 1 in the cycle after its raw `lane_los` input is 1. It stays 1 until a read of C00Ah, after which it is 0 again.
- R8: An event present in the same cycle as a status read is not reported by that read. It stays latched and is reported by the next read.
- R9: A write to C00Fh with bit 15 set raises `soft_rst_pulse` for exactly the following cycle. A write with bit 15 clear gives no pulse.
- R10: A soft reset leaves every configuration field unchanged. C00Fh always reads 0000h.
- R11: Reads of unmapped addresses return 0000h. Writes to C00Ah or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_copper | input | 1 | Default profile select: 1 selects copper, 0 selects fiber |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| lane_sigdet | input | 4 | Raw signal present, one bit per lane |
| lane_los | input | 4 | Raw loss of signal, one bit per lane |
| eq_coeff | output | 4 | Equalizer boost coefficient |
| amp_ctrl | output | 4 | Output amplitude control |
| preemph_en | output | 4 | Per-lane pre-emphasis enables |
| test_ctl | output | 2 | Internal test field |
| soft_rst_pulse | output | 1 | One-cycle datapath reset pulse |

## Verification
Every result in this block is due one clock edge after its cause. A write shows on the field outputs, and on `soft_rst_pulse`, right after the edge that samples the strobe. A read shows on `reg_rdata` after the edge that samples `reg_re`. A raw lane event is latched at the edge that samples it. The bench drives inputs on falling edges and samples at the next falling edge, so each check lands exactly one edge after its stimulus. The same-cycle case (R8) drives the event and the read strobe on the same falling edge. It then expects the clean value from the first read and the event from the second.

// File: rtl/pma_regs_pkg.sv
package pma_regs_pkg;
    localparam int N_LANES = 4;
    localparam int DW      = 16;
    localparam int AW      = 16;
    localparam int FW      = 4;

    localparam logic [AW-1:0] ADR_EQ   = 16'hC006;
    localparam logic [AW-1:0] ADR_STAT = 16'hC00A;
    localparam logic [AW-1:0] ADR_ADJ  = 16'hC00B;
    localparam logic [AW-1:0] ADR_SRST = 16'hC00F;

    localparam int SRST_BIT = 15;

    typedef struct packed {
        logic [FW-1:0]      eq;
        logic [FW-1:0]      amp;
        logic [N_LANES-1:0] pre;
        logic [1:0]         tst;
    } cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EQ,
        SEL_STAT,
        SEL_ADJ,
        SEL_SRST
    } sel_e;

    function automatic sel_e decode(input logic [AW-1:0] a);
        case (a)
            ADR_EQ:   return SEL_EQ;
            ADR_STAT: return SEL_STAT;
            ADR_ADJ:  return SEL_ADJ;
            ADR_SRST: return SEL_SRST;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic cfg_t cfg_default(input logic copper);
        cfg_t c;
        c.eq  = copper ? 4'hC : 4'h0;
        c.amp = copper ? 4'h3 : 4'h5;
        c.pre = copper ? '1   : '0;
        c.tst = 2'b00;
        return c;
    endfunction
endpackage

// File: rtl/pma_status_latch.sv
module pma_status_latch #(
    parameter int N = pma_regs_pkg::N_LANES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] sig_ok,
    input  logic [N-1:0] loss,
    output logic [N-1:0] sd_q,
    output logic [N-1:0] los_q
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                sd_q[i]  <= 1'b1;
                los_q[i] <= 1'b0;
            end else begin
                sd_q[i]  <= (sd_q[i] | clr) & sig_ok[i];
                los_q[i] <= (los_q[i] & ~clr) | loss[i];
            end
        end
    end
endmodule

// File: rtl/pma_cfg_regs.sv
module pma_cfg_regs
    import pma_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          copper,
    input  logic          we,
    input  sel_e          sel,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_default(copper);
        end else if (we) begin
            case (sel)
                SEL_EQ:  cfg.eq <= wdata[FW-1:0];
                SEL_ADJ: begin
                    cfg.amp <= wdata[2+N_LANES +: FW];
                    cfg.pre <= wdata[2 +: N_LANES];
                    cfg.tst <= wdata[1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pma_soft_reset.sv
module pma_soft_reset (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= fire;
    end
endmodule

// File: rtl/pma_reg_bank.sv
module pma_reg_bank
    import pma_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_copper,
    input  logic [15:0]   reg_addr,
    input  logic [15:0]   reg_wdata,
    input  logic          reg_we,
    input  logic          reg_re,
    output logic [15:0]   reg_rdata,
    input  logic [3:0]    lane_sigdet,
    input  logic [3:0]    lane_los,
    output logic [3:0]    eq_coeff,
    output logic [3:0]    amp_ctrl,
    output logic [3:0]    preemph_en,
    output logic [1:0]    test_ctl,
    output logic          soft_rst_pulse
);
    sel_e               sel;
    cfg_t               cfg;
    logic [N_LANES-1:0] sd_lat;
    logic [N_LANES-1:0] los_lat;
    logic               stat_rd;
    logic [DW-1:0]      rd_mux;

    assign sel     = decode(reg_addr);
    assign stat_rd = reg_re && (sel == SEL_STAT);

    pma_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .copper (mode_copper),
        .we     (reg_we),
        .sel    (sel),
        .wdata  (reg_wdata),
        .cfg    (cfg)
    );

    pma_status_latch #(.N(N_LANES)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .clr    (stat_rd),
        .sig_ok (lane_sigdet),
        .loss   (lane_los),
        .sd_q   (sd_lat),
        .los_q  (los_lat)
    );

    pma_soft_reset u_srst (
        .clk   (clk),
        .rst   (rst),
        .fire  (reg_we && (sel == SEL_SRST) && reg_wdata[SRST_BIT]),
        .pulse (soft_rst_pulse)
    );

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_EQ:   rd_mux[FW-1:0] = cfg.eq;
            SEL_STAT: rd_mux[2*N_LANES-1:0] = {sd_lat, los_lat};
            SEL_ADJ:  rd_mux[2+N_LANES+FW-1:0] = {cfg.amp, cfg.pre, cfg.tst};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_mux;
    end

    assign eq_coeff   = cfg.eq;
    assign amp_ctrl   = cfg.amp;
    assign preemph_en = cfg.pre;
    assign test_ctl   = cfg.tst;
endmodule

// File: rtl/pma_reg_bank_sva.sv
module pma_reg_bank_sva
    import pma_regs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] reg_addr,
    input logic [15:0] reg_wdata,
    input logic        reg_we,
    input logic        reg_re,
    input logic [15:0] reg_rdata,
    input logic [3:0]  lane_sigdet,
    input logic [3:0]  lane_los,
    input logic [3:0]  sd_lat,
    input logic [3:0]  los_lat,
    input logic [3:0]  eq_coeff,
    input logic [3:0]  amp_ctrl,
    input logic        soft_rst_pulse
);
    AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |=> !soft_rst_pulse); // R9
    AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> $past(reg_we && reg_addr == ADR_SRST && reg_wdata[15])); // R9
    AST_SRST_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> ($stable(eq_coeff) && $stable(amp_ctrl))); // R10
    AST_LOS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (lane_los != 4'h0) |=> ((los_lat & $past(lane_los)) == $past(lane_los))); // R7
    AST_SIGDET_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (lane_sigdet != 4'hF) |=> ((sd_lat & ~$past(lane_sigdet)) == 4'h0)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_re && decode(reg_addr) == SEL_NONE) |=> (reg_rdata == 16'h0000)); // R11
    AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == ADR_STAT) |=> (reg_rdata[15:8] == 8'h00)); // R5
endmodule

bind pma_reg_bank pma_reg_bank_sva u_sva (
    .clk            (clk),
    .rst            (rst),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_we         (reg_we),
    .reg_re         (reg_re),
    .reg_rdata      (reg_rdata),
    .lane_sigdet    (lane_sigdet),
    .lane_los       (lane_los),
    .sd_lat         (sd_lat),
    .los_lat        (los_lat),
    .eq_coeff       (eq_coeff),
    .amp_ctrl       (amp_ctrl),
    .soft_rst_pulse (soft_rst_pulse)
);

// File: tb/sim_pma_reg_bank.sv
`timescale 1ns/1ps
module sim_pma_reg_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_copper = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;
    logic [3:0]  lane_sigdet = 4'hF;
    logic [3:0]  lane_los = 4'h0;
    logic [3:0]  eq_coeff, amp_ctrl, preemph_en;
    logic [1:0]  test_ctl;
    logic        soft_rst_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic pulse_seen;

    always #2.5 clk = ~clk;

    pma_reg_bank u0 (.*);

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset(input logic copper);
        @(negedge clk);
        mode_copper = copper;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        pulse_seen = soft_rst_pulse;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r;

        // R1 fiber defaults
        do_reset(1'b0);
        chk("R1 eq", {12'h0, eq_coeff}, 16'h0);
        chk("R1 amp", {12'h0, amp_ctrl}, 16'h5);
        chk("R1 pre", {12'h0, preemph_en}, 16'h0);
        chk("R1 tst", {14'h0, test_ctl}, 16'h0);
        rd(16'hC00A, r); chk("R1 status", r, 16'h00F0);
        rd(16'hC00B, r); chk("R1 adj read", r, {6'h0, 4'h5, 4'h0, 2'b00});

        // R2 copper defaults
        do_reset(1'b1);
        chk("R2 eq", {12'h0, eq_coeff}, 16'hC);
        chk("R2 amp", {12'h0, amp_ctrl}, 16'h3);
        chk("R2 pre", {12'h0, preemph_en}, 16'hF);
        chk("R2 tst", {14'h0, test_ctl}, 16'h0);
        rd(16'hC006, r); chk("R2 eq read", r, 16'h000C);

        // R3 sweep of all coefficients, high bits written as ones
        for (int v = 0; v < 16; v++) begin
            wr(16'hC006, 16'hFFF0 | v[15:0]);
            chk("R3 eq port", {12'h0, eq_coeff}, v[15:0]);
            rd(16'hC006, r); chk("R3 eq read", r, v[15:0]);
        end

        // R4 sweep of all 10-bit adjust values
        for (int v = 0; v < 1024; v++) begin
            wr(16'hC00B, 16'hFC00 | v[15:0]);
            chk("R4 fields", {2'b0, amp_ctrl, preemph_en, test_ctl, 4'h0},
                {2'b0, v[9:6], v[5:2], v[1:0], 4'h0});
            if (v % 64 == 0) begin
                rd(16'hC00B, r); chk("R4 read", r, v[15:0]);
            end
        end

        // R5 read data holds between reads
        rd(16'hC006, r);
        reg_addr = 16'hC00B;
        @(negedge clk); @(negedge clk);
        chk("R5 hold", reg_rdata, 16'h000F);

        // R6 R7 sweep of event patterns on all lanes
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            lane_los = p[3:0]; lane_sigdet = ~p[3:0];
            @(negedge clk);
            lane_los = 4'h0; lane_sigdet = 4'hF;
            @(negedge clk);
            rd(16'hC00A, r); chk("R6 R7 latched", r, {8'h0, ~p[3:0], p[3:0]});
            rd(16'hC00A, r); chk("R6 R7 restored", r, 16'h00F0);
        end

        // R8 event in the same cycle as the read
        @(negedge clk);
        reg_addr = 16'hC00A; reg_re = 1'b1;
        lane_los = 4'b0010; lane_sigdet = 4'b1110;
        @(negedge clk);
        reg_re = 1'b0; lane_los = 4'h0; lane_sigdet = 4'hF;
        chk("R8 first read", reg_rdata, 16'h00F0);
        rd(16'hC00A, r); chk("R8 second read", r, 16'h00E2);

        // R9 R10 soft reset
        wr(16'hC006, 16'h0007);
        wr(16'hC00B, 16'h02A5);
        wr(16'hC00F, 16'h8000);
        chk("R9 pulse high", {15'h0, pulse_seen}, 16'h1);
        @(negedge clk);
        chk("R9 pulse single", {15'h0, soft_rst_pulse}, 16'h0);
        chk("R10 eq kept", {12'h0, eq_coeff}, 16'h7);
        rd(16'hC00B, r); chk("R10 adj kept", r, 16'h02A5);
        rd(16'hC00F, r); chk("R10 srst reads 0", r, 16'h0000);
        wr(16'hC00F, 16'h7FFF);
        chk("R9 no pulse", {15'h0, pulse_seen}, 16'h0);

        // R11 unmapped reads and ignored writes
        wr(16'hC00A, 16'hFFFF);
        rd(16'hC00A, r); chk("R11 status write ignored", r, 16'h00F0);
        for (int a = 16'hC000; a < 16'hC010; a++) begin
            if (a != 16'hC006 && a != 16'hC00A && a != 16'hC00B && a != 16'hC00F) begin
                wr(a[15:0], 16'hFFFF);
                rd(a[15:0], r); chk("R11 unmapped", r, 16'h0000);
            end
        end
        rd(16'hC006, r); chk("R11 eq untouched", r, 16'h0007);
        rd(16'hC00B, r); chk("R11 adj untouched", r, 16'h02A5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule